// File: doc/BRIEF.md
# Trigger-Controlled Timer Slave Controller

This block is a timer counter whose clocking, starting, gating and restarting are governed by one trigger line. That line is chosen from eight sources: four internal triggers from other timers, the input-1 edge detector, filtered input 1, filtered input 2 and the filtered external trigger. A three-bit mode code decides what a trigger does to the counter. It can be ignored, so the counter runs freely on the internal clock. It can restart the counter on a rising edge. It can gate counting by its level. It can start counting on an edge. Or each of its edges can step the counter by one.

The counter counts up to a reload value, wraps to zero and raises a one-cycle update event. A registered trigger output carries each rising edge of the selected trigger to slave timers. With the sync option on, the trigger's effect on this counter is held back one clock so that master and slaves act on the same event together. The mode code can be written directly, or through a preload stage. In that case it waits in a shadow register until an update event or an index pulse, depending on the chosen source.

Top module: `tslv_ctrl`

## Requirements
- R1: After reset, `count`, `update_evt`, `cnt_en`, `active_mode` and `trig_out` are all 0.
- R2: In mode 0 (and in the unused codes 1 to 3), the counter advances by one on every clock while `cnt_en` is 1. It holds while `cnt_en` is 0. On the clock where it equals `reload_val`, it becomes 0 and `update_evt` is 1 for that one cycle.
- R3: `trig_sel` values 0 to 3 pick `int_trig[0]` to `int_trig[3]`. Value 4 picks `ti1_edge`, 5 picks `ti1_filt`, 6 picks `ti2_filt` and 7 picks `ext_trig_filt`. Unselected sources have no effect.
- R4: In mode 4, a rising edge of the trigger sets the count to 0 and raises `update_evt` on that clock, whether or not the counter is enabled. Between edges the counter behaves as in R2.
- R5: In mode 5, the enabled counter advances only on clocks where the trigger level is 1. While the level is 0 it holds its value and is not cleared.
- R6: In mode 6, a rising trigger edge sets `cnt_en` on that clock and counting starts on the next clock. A later low trigger does not stop it. Only `cnt_en_clr` clears the enable.
- R7: In mode 7, the enabled counter advances by one for each rising edge of the trigger and not otherwise. While `cnt_en` is 0, edges do not count.
- R8: `trig_out` is 1 for exactly one clock after each rising edge of the selected trigger. When `sync_en` is 1, the trigger's effect on the counter comes one clock later than when `sync_en` is 0, in the same cycle that `trig_out` is high.
- R9: With `mode_preload_en`=1 and `mode_preload_src`=0, a written mode goes to a shadow register. `active_mode` changes to it only on the clock after `update_evt` is 1.
- R10: With `mode_preload_en`=1 and `mode_preload_src`=1, the shadow mode is copied to `active_mode` only on a clock where `index_pulse` is 1. Update events do not transfer it.
- R11: With `mode_preload_en`=0, a mode write shows on `active_mode` right after the write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en_set | input | 1 | Pulse that sets the counter enable |
| cnt_en_clr | input | 1 | Pulse that clears the counter enable |
| reload_val | input | CNT_W | Count at which the counter wraps to 0 |
| trig_sel | input | SEL_W | Trigger source select |
| int_trig | input | NUM_ITR | Internal triggers from other timers |
| ti1_edge | input | 1 | Input-1 edge detector output |
| ti1_filt | input | 1 | Filtered timer input 1 |
| ti2_filt | input | 1 | Filtered timer input 2 |
| ext_trig_filt | input | 1 | Filtered external trigger |
| sync_en | input | 1 | Delay the trigger effect one clock for master/slave lock-step |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode code written |
| mode_preload_en | input | 1 | Route mode writes through the shadow register |
| mode_preload_src | input | 1 | Shadow transfer event: 0 update, 1 index |
| index_pulse | input | 1 | Index event |
| count | output | CNT_W | Counter value |
| update_evt | output | 1 | One-cycle pulse on wrap or reset-mode restart |
| cnt_en | output | 1 | Counter enable state |
| active_mode | output | 3 | Mode code in force |
| trig_out | output | 1 | Registered rising-edge pulse of the selected trigger |

## Verification
A wrong trigger-edge register shows within one clock. The counter either misses an edge or counts a held level twice in mode 7, and `trig_out` stretches past one cycle. A wrong enable or mode register appears at the next clock as a count that moves when it should hold, or the reverse. The gated and external-clock sweeps expose it as a count that differs from the number of high clocks or edges applied. A shadow register that transfers at the wrong time shows on `active_mode` one clock after the stray update or index event.

// File: rtl/tslv_pkg.sv
package tslv_pkg;
    typedef enum logic [2:0] {
        MODE_FREE    = 3'd0,
        MODE_RESET   = 3'd4,
        MODE_GATED   = 3'd5,
        MODE_TRIGGER = 3'd6,
        MODE_EXTCLK  = 3'd7
    } mode_e;

    localparam int unsigned MODE_W   = 3;
    localparam int unsigned FIXED_SRC = 4;
endpackage

// File: rtl/tslv_trig_path.sv
module tslv_trig_path #(
    parameter int unsigned NUM_ITR = 4,
    localparam int unsigned NUM_SRC = NUM_ITR + tslv_pkg::FIXED_SRC,
    localparam int unsigned SEL_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] src,
    input  logic               sync_en,
    output logic               lvl_eff,
    output logic               edge_eff,
    output logic               pulse_out
);
    typedef struct packed {
        logic trig;
        logic pulse;
    } tp_state_t;

    tp_state_t st_d, st_q;
    logic      raw;
    logic      edge_raw;

    always_comb begin
        raw       = src[sel];
        edge_raw  = raw & ~st_q.trig;
        st_d      = st_q;
        st_d.trig = raw;
        st_d.pulse = edge_raw;
        lvl_eff   = sync_en ? st_q.trig  : raw;
        edge_eff  = sync_en ? st_q.pulse : edge_raw;
        pulse_out = st_q.pulse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |=> !pulse_out);
endmodule

// File: rtl/tslv_mode_reg.sv
module tslv_mode_reg #(
    localparam int unsigned MODE_W = tslv_pkg::MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [MODE_W-1:0] wdata,
    input  logic              pre_en,
    input  logic              pre_src,
    input  logic              upd,
    input  logic              index,
    output logic [MODE_W-1:0] mode
);
    typedef struct packed {
        logic [MODE_W-1:0] active;
        logic [MODE_W-1:0] shadow;
    } mr_state_t;

    mr_state_t st_d, st_q;
    logic      xfer;

    always_comb begin
        st_d = st_q;
        xfer = pre_src ? index : upd;
        if (pre_en) begin
            if (xfer) st_d.active = st_q.shadow;
        end else if (wr) begin
            st_d.active = wdata;
        end
        if (wr) st_d.shadow = wdata;
        mode = st_q.active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r9_hold_until_update: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && !pre_src && !upd) |=> $stable(mode));
    a_r10_hold_until_index: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && pre_src && !index) |=> $stable(mode));
    a_r11_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_en && wr) |=> (mode == $past(wdata)));
endmodule

// File: rtl/tslv_count_core.sv
module tslv_count_core
    import tslv_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    localparam int unsigned MW   = tslv_pkg::MODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MW-1:0]    mode,
    input  logic             lvl,
    input  logic             trig_edge,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             en,
    output logic             upd
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             upd;
    } cc_state_t;

    cc_state_t st_d, st_q;
    logic      adv;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        case (mode)
            MODE_GATED:  adv = st_q.en & lvl;
            MODE_EXTCLK: adv = st_q.en & trig_edge;
            default:     adv = st_q.en;
        endcase

        if (mode == MODE_RESET && trig_edge) begin
            st_d.cnt = '0;
            st_d.upd = 1'b1;
        end else if (adv) begin
            if (st_q.cnt == reload) begin
                st_d.cnt = '0;
                st_d.upd = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (en_clr) st_d.en = 1'b0;
        if (en_set) st_d.en = 1'b1;
        if (mode == MODE_TRIGGER && trig_edge) st_d.en = 1'b1;

        cnt = st_q.cnt;
        en  = st_q.en;
        upd = st_q.upd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> (cnt == '0));
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RESET && trig_edge) |=> (cnt == '0 && upd));
    a_r5_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_GATED && !lvl) |=> $stable(cnt));
    a_r6_hw_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TRIGGER && trig_edge) |=> en);
endmodule

// File: rtl/tslv_ctrl.sv
module tslv_ctrl #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned NUM_ITR = 4,
    localparam int unsigned NUM_SRC = NUM_ITR + tslv_pkg::FIXED_SRC,
    localparam int unsigned SEL_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_en_set,
    input  logic               cnt_en_clr,
    input  logic [CNT_W-1:0]   reload_val,
    input  logic [SEL_W-1:0]   trig_sel,
    input  logic [NUM_ITR-1:0] int_trig,
    input  logic               ti1_edge,
    input  logic               ti1_filt,
    input  logic               ti2_filt,
    input  logic               ext_trig_filt,
    input  logic               sync_en,
    input  logic               mode_wr,
    input  logic [2:0]         mode_wdata,
    input  logic               mode_preload_en,
    input  logic               mode_preload_src,
    input  logic               index_pulse,
    output logic [CNT_W-1:0]   count,
    output logic               update_evt,
    output logic               cnt_en,
    output logic [2:0]         active_mode,
    output logic               trig_out
);
    logic [NUM_SRC-1:0] src_vec;
    logic               lvl_eff;
    logic               edge_eff;

    assign src_vec = {ext_trig_filt, ti2_filt, ti1_filt, ti1_edge, int_trig};

    tslv_trig_path #(.NUM_ITR(NUM_ITR)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (trig_sel),
        .src       (src_vec),
        .sync_en   (sync_en),
        .lvl_eff   (lvl_eff),
        .edge_eff  (edge_eff),
        .pulse_out (trig_out)
    );

    tslv_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (mode_wr),
        .wdata   (mode_wdata),
        .pre_en  (mode_preload_en),
        .pre_src (mode_preload_src),
        .upd     (update_evt),
        .index   (index_pulse),
        .mode    (active_mode)
    );

    tslv_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (active_mode),
        .lvl       (lvl_eff),
        .trig_edge (edge_eff),
        .en_set    (cnt_en_set),
        .en_clr    (cnt_en_clr),
        .reload    (reload_val),
        .cnt       (count),
        .en        (cnt_en),
        .upd       (update_evt)
    );
endmodule

// File: tb/tslv_ctrl_test.sv
module tslv_ctrl_test;
    localparam int PERIOD = 10;
    localparam int CW     = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en_set, en_clr;
    logic [CW-1:0] reload;
    logic [2:0]    tsel;
    logic [7:0]    src;
    logic          sync;
    logic          mwr;
    logic [2:0]    mdata;
    logic          pre_en, pre_src, idx;
    logic [CW-1:0] count;
    logic          upd, en, tout;
    logic [2:0]    amode;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    tslv_ctrl #(.CNT_W(CW), .NUM_ITR(4)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_en_set(en_set), .cnt_en_clr(en_clr),
        .reload_val(reload), .trig_sel(tsel), .int_trig(src[3:0]),
        .ti1_edge(src[4]), .ti1_filt(src[5]), .ti2_filt(src[6]),
        .ext_trig_filt(src[7]), .sync_en(sync), .mode_wr(mwr),
        .mode_wdata(mdata), .mode_preload_en(pre_en),
        .mode_preload_src(pre_src), .index_pulse(idx), .count(count),
        .update_evt(upd), .cnt_en(en), .active_mode(amode), .trig_out(tout)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en_set = 0; en_clr = 0; reload = '0; tsel = '0;
        src = '0; sync = 0; mwr = 0; mdata = '0; pre_en = 0; pre_src = 0; idx = 0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic set_mode(input int m);
        mdata = 3'(m); mwr = 1'b1; tick(); mwr = 1'b0;
    endtask

    task automatic enable();
        en_set = 1'b1; tick(); en_set = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 count", int'(count), 0);
        chk("R1 update", int'(upd), 0);
        chk("R1 enable", int'(en), 0);
        chk("R1 mode", int'(amode), 0);
        chk("R1 trig_out", int'(tout), 0);

        // R2: free running with wrap, several reload values
        for (int a = 0; a <= 4; a++) begin
            do_reset();
            reload = CW'(a);
            enable();
            for (int k = 1; k <= 12; k++) begin
                tick();
                chk("R2 count", int'(count), k % (a + 1));
                chk("R2 update", int'(upd), (k % (a + 1) == 0) ? 1 : 0);
            end
        end
        // R2: unused code behaves as free running, clear holds
        do_reset();
        reload = 8'd100;
        set_mode(2);
        enable();
        repeat (7) tick();
        chk("R2 code2 count", int'(count), 7);
        en_clr = 1'b1; tick(); en_clr = 1'b0;
        repeat (4) tick();
        chk("R2 held after clear", int'(count), 8);

        // R3 / R7: every trigger source in edge-count mode
        for (int s = 0; s < 8; s++) begin
            do_reset();
            reload = 8'd200;
            tsel = 3'(s);
            set_mode(7);
            src[s] = 1'b1; tick(); src[s] = 1'b0; tick();
            chk("R7 no count while disabled", int'(count), 0);
            enable();
            for (int i = 0; i < 3; i++) begin
                src[s] = 1'b1; tick(); src[s] = 1'b0; tick();
            end
            for (int i = 0; i < 2; i++) begin
                src[(s + 1) % 8] = 1'b1; tick(); src[(s + 1) % 8] = 1'b0; tick();
            end
            chk("R3 R7 edges counted", int'(count), 3);
        end
        // R7: a held level counts once
        do_reset();
        reload = 8'd200; tsel = 3'd1;
        set_mode(7); enable();
        src[1] = 1'b1; repeat (5) tick(); src[1] = 1'b0; tick();
        chk("R7 held level", int'(count), 1);

        // R5: gated by level
        do_reset();
        reload = 8'd200; tsel = 3'd5;
        set_mode(5); enable();
        src[5] = 1'b1; repeat (4) tick();
        chk("R5 high window", int'(count), 4);
        src[5] = 1'b0; repeat (3) tick();
        chk("R5 hold while low", int'(count), 4);
        src[5] = 1'b1; repeat (2) tick();
        chk("R5 resumes", int'(count), 6);

        // R4: restart on edge
        do_reset();
        reload = 8'd50; tsel = 3'd7;
        set_mode(4); enable();
        repeat (10) tick();
        chk("R4 before edge", int'(count), 10);
        src[7] = 1'b1; tick();
        chk("R4 restart count", int'(count), 0);
        chk("R4 restart update", int'(upd), 1);
        tick();
        chk("R4 counts after", int'(count), 1);
        chk("R4 update single", int'(upd), 0);

        // R6: trigger start
        do_reset();
        reload = 8'd200; tsel = 3'd2;
        set_mode(6);
        repeat (3) tick();
        chk("R6 idle", int'(count), 0);
        src[2] = 1'b1; tick();
        chk("R6 enable set", int'(en), 1);
        chk("R6 start next clock", int'(count), 0);
        src[2] = 1'b0; repeat (3) tick();
        chk("R6 keeps running", int'(count), 3);
        chk("R6 enable kept", int'(en), 1);
        en_clr = 1'b1; tick(); en_clr = 1'b0;
        repeat (3) tick();
        chk("R6 stopped by clear", int'(count), 4);
        chk("R6 enable cleared", int'(en), 0);

        // R8: trigger output and sync delay
        do_reset();
        reload = 8'd200; tsel = 3'd0;
        set_mode(7); enable();
        src[0] = 1'b1; tick();
        chk("R8 direct count", int'(count), 1);
        chk("R8 direct trig_out", int'(tout), 1);
        src[0] = 1'b0; tick();
        chk("R8 trig_out one cycle", int'(tout), 0);
        do_reset();
        reload = 8'd200; tsel = 3'd0; sync = 1'b1;
        set_mode(7); enable();
        src[0] = 1'b1; tick();
        chk("R8 sync trig_out", int'(tout), 1);
        chk("R8 sync not yet", int'(count), 0);
        tick();
        chk("R8 sync count", int'(count), 1);
        chk("R8 sync trig_out drop", int'(tout), 0);
        tick();
        chk("R8 sync held level", int'(count), 1);
        chk("R8 sync trig_out low", int'(tout), 0);

        // R9: preload on update
        do_reset();
        reload = 8'd3; pre_en = 1'b1; pre_src = 1'b0; tsel = 3'd3;
        enable();
        set_mode(5);
        chk("R9 held after write", int'(amode), 0);
        tick(); tick(); tick();
        chk("R9 wrap", int'(upd), 1);
        chk("R9 still old", int'(amode), 0);
        tick();
        chk("R9 transferred", int'(amode), 5);
        chk("R9 last free count", int'(count), 1);
        tick();
        chk("R9 now gated", int'(count), 1);

        // R10: preload on index
        do_reset();
        reload = 8'd1; pre_en = 1'b1; pre_src = 1'b1;
        enable();
        set_mode(6);
        repeat (6) tick();
        chk("R10 updates ignored", int'(amode), 0);
        idx = 1'b1; tick(); idx = 1'b0;
        chk("R10 index transfer", int'(amode), 6);

        // R11: direct write
        do_reset();
        set_mode(4);
        chk("R11 immediate", int'(amode), 4);

        // R1: reset mid-run
        reload = 8'd100; enable(); repeat (5) tick();
        do_reset();
        chk("R1 count after reset", int'(count), 0);
        chk("R1 mode after reset", int'(amode), 0);

        finished = 1;
        finish_run();
    end
endmodule